// File: doc/BRIEF.md
# Control Port Command Latch

This block sits behind the control port of a video controller. The block assembles a memory access command from two consecutive 16-bit control writes. The first word supplies the low fourteen address bits and the two low access-code bits, then marks the command as half-written. The second word supplies the two top address bits and the four upper code bits, which completes the command. A first word whose top two bits are `2'b10` is a register write. It is reported as a one-cycle pulse with its index and data, and it leaves the command untouched.

When a command completes, the block pulses a flush of the read prefetch. It also decides whether a DMA transfer begins. Copy and memory-sourced transfers start at once. A fill transfer is armed and starts on the next data-port write. Any data-port access or status read abandons a half-written command. The block also drives the two status bits that show whether the write queue is empty or full. All pins are plain level or pulse signals sampled every clock, so there is no valid/ready handshake and no back-pressure. The caller asserts at most the strobes it means, and within a cycle a control write takes priority over the other strobes.

Top module: `ctl_cmd_latch`

## Requirements
- R1: Synchronous reset clears address, code, pending, DMA start, prefetch flush and register-write pulse to 0.
- R2: A control write with no command pending and `wdata[15:14]` not equal to `2'b10` loads address[13:0] from wdata[13:0] and code[1:0] from wdata[15:14]. It keeps address[15:14] and code[5:2] and sets pending on the next cycle.
- R3: A control write while pending loads address[15:14] from wdata[1:0] and code[5:2] from wdata[7:4]. It clears pending and raises the prefetch flush for exactly one cycle.
- R4: A control write with no command pending and `wdata[15:14] == 2'b10` pulses the register write for one cycle with index wdata[12:8] and data wdata[7:0]. Pending stays 0, and address and code are unchanged.
- R5: A data-port read or write while pending clears pending and pulses the prefetch flush. A data access with nothing pending gives no flush.
- R6: A status read clears pending without a flush and without changing address or code.
- R7: When a command completes with code bit 5 set (wdata[7]), DMA enabled and source mode not `2'b10`, DMA start pulses for one cycle on the next cycle. It does not pulse if DMA is disabled or code bit 5 is clear.
- R8: Source mode `2'b10` (fill) arms instead of starting. The next data-port write pulses DMA start once, and later data writes do not. A new first word clears the arming.
- R9: The queue-empty flag (status bit 9) is 1 exactly when the queue level is 0. The queue-full flag (status bit 8) is 1 exactly when the level equals `Q_DEPTH`.
- R10: When a control write coincides with data-port or status strobes, only the control write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Status (control-port) read strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| wdata | input | 16 | Value written to the control port |
| dma_en | input | 1 | DMA enable mode bit |
| src_mode | input | 2 | DMA source mode (`2'b10` = fill) |
| q_level | input | LVL_W | Current write-queue occupancy |
| acc_addr | output | 16 | Assembled access address |
| acc_code | output | 6 | Assembled access code |
| cmd_pending | output | 1 | First word received, second awaited |
| dma_start | output | 1 | One-cycle DMA start pulse |
| prefetch_flush | output | 1 | One-cycle read-prefetch invalidate |
| reg_wr | output | 1 | One-cycle register-write pulse |
| reg_idx | output | 5 | Register index of the write |
| reg_data | output | 8 | Register data of the write |
| q_empty | output | 1 | Status bit 9: queue empty |
| q_full | output | 1 | Status bit 8: queue full |

## Verification
The hardest case to reach is a fill transfer. The arming must survive idle cycles and fire on exactly one later data write. It must also be dropped when a new first word arrives before any data write. The stimulus completes a fill command and idles a cycle. It then issues two data writes, and separately starts a fresh command over an armed fill and checks that a following data write stays silent. Coincident strobes while a command is half-written are driven on purpose to show that the control write wins.

// File: rtl/ctl_cmd_pkg.sv
package ctl_cmd_pkg;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 6;
  localparam int LOW_W  = ADDR_W - 2;

  localparam logic [1:0] HEAD_REGSEL = 2'b10;
  localparam logic [1:0] SRC_FILL    = 2'b10;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_HEAD,
    EV_TAIL,
    EV_REG,
    EV_DATA,
    EV_STAT
  } ev_e;
endpackage

// File: rtl/cmd_word_decode.sv
module cmd_word_decode
  import ctl_cmd_pkg::*;
(
  input  logic        ctl_wr,
  input  logic        ctl_rd,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic        pending,
  input  logic [15:0] wdata,
  output ev_e         ev,
  output logic        dwr_hit
);
  always_comb begin
    ev = EV_IDLE;
    if (ctl_wr) begin
      if (pending)                         ev = EV_TAIL;
      else if (wdata[15:14] == HEAD_REGSEL) ev = EV_REG;
      else                                 ev = EV_HEAD;
    end else if (data_wr || data_rd) begin
      ev = EV_DATA;
    end else if (ctl_rd) begin
      ev = EV_STAT;
    end
  end

  assign dwr_hit = (ev == EV_DATA) && data_wr;
endmodule

// File: rtl/cmd_state.sv
module cmd_state
  import ctl_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ev_e               ev,
  input  logic [15:0]       wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [CODE_W-1:0] code,
  output logic              pending,
  output logic              flush,
  output logic              reg_wr,
  output logic [4:0]        reg_idx,
  output logic [7:0]        reg_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr     <= '0;
      code     <= '0;
      pending  <= 1'b0;
      flush    <= 1'b0;
      reg_wr   <= 1'b0;
      reg_idx  <= '0;
      reg_data <= '0;
    end else begin
      flush  <= 1'b0;
      reg_wr <= 1'b0;
      unique case (ev)
        EV_HEAD: begin
          addr[LOW_W-1:0] <= wdata[LOW_W-1:0];
          code[1:0]       <= wdata[15:14];
          pending         <= 1'b1;
        end
        EV_TAIL: begin
          addr[ADDR_W-1:LOW_W] <= wdata[1:0];
          code[CODE_W-1:2]     <= wdata[7:4];
          pending              <= 1'b0;
          flush                <= 1'b1;
        end
        EV_REG: begin
          reg_wr   <= 1'b1;
          reg_idx  <= wdata[12:8];
          reg_data <= wdata[7:0];
        end
        EV_DATA: begin
          if (pending) begin
            pending <= 1'b0;
            flush   <= 1'b1;
          end
        end
        EV_STAT: pending <= 1'b0;
        default: ;
      endcase
    end
  end

  p_head_pend_r2: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_HEAD) |=> (pending && addr[LOW_W-1:0] == $past(wdata[LOW_W-1:0])
                         && $stable(addr[ADDR_W-1:LOW_W])));

  p_tail_flush_r3: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_TAIL) |=> (!pending && flush && code[CODE_W-1:2] == $past(wdata[7:4])));

  p_flush_single_r3: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!flush || $past(ev == EV_TAIL) || $past(ev == EV_DATA)));

  p_reg_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_REG) |=> (reg_wr && !pending && $stable(addr) && $stable(code)));

  p_data_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_DATA && pending) |=> (!pending && flush));

  p_data_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_DATA && !pending) |=> !flush);

  p_stat_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_STAT) |=> (!pending && !flush && $stable(addr)));
endmodule

// File: rtl/dma_trigger.sv
module dma_trigger
  import ctl_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ev_e        ev,
  input  logic       dwr_hit,
  input  logic       xfer_bit,
  input  logic       dma_en,
  input  logic [1:0] src_mode,
  output logic       dma_start
);
  logic armed;
  logic want;

  assign want = xfer_bit && dma_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      dma_start <= 1'b0;
    end else begin
      dma_start <= 1'b0;
      if (ev == EV_TAIL) begin
        armed     <= want && (src_mode == SRC_FILL);
        dma_start <= want && (src_mode != SRC_FILL);
      end else if (ev == EV_HEAD) begin
        armed <= 1'b0;
      end else if (dwr_hit && armed) begin
        armed     <= 1'b0;
        dma_start <= 1'b1;
      end
    end
  end

  p_dma_single_r7: assert property (@(posedge clk) disable iff (rst)
    dma_start |=> !dma_start);

  p_dma_off_r7: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_TAIL && !dma_en) |=> !dma_start);

  p_fill_wait_r8: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_TAIL && src_mode == SRC_FILL) |=> !dma_start);

  p_fill_once_r8: assert property (@(posedge clk) disable iff (rst)
    (dwr_hit && !armed) |=> !dma_start);
endmodule

// File: rtl/queue_flags.sv
module queue_flags #(
  parameter int Q_DEPTH = 4,
  parameter int LVL_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  localparam logic [LVL_W-1:0] TOP = LVL_W'(Q_DEPTH);

  assign empty = (level == '0);
  assign full  = (level == TOP);

  always_comb begin
    if (empty && full) assert (Q_DEPTH == 0) else $error("p_flags_excl_r9");
  end
endmodule

// File: rtl/ctl_cmd_latch.sv
module ctl_cmd_latch
  import ctl_cmd_pkg::*;
#(
  parameter int Q_DEPTH = 4,
  parameter int LVL_W   = $clog2(Q_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             data_wr,
  input  logic             data_rd,
  input  logic [15:0]      wdata,
  input  logic             dma_en,
  input  logic [1:0]       src_mode,
  input  logic [LVL_W-1:0] q_level,
  output logic [15:0]      acc_addr,
  output logic [5:0]       acc_code,
  output logic             cmd_pending,
  output logic             dma_start,
  output logic             prefetch_flush,
  output logic             reg_wr,
  output logic [4:0]       reg_idx,
  output logic [7:0]       reg_data,
  output logic             q_empty,
  output logic             q_full
);
  ev_e  ev;
  logic dwr_hit;

  cmd_word_decode u_dec (
    .ctl_wr  (ctl_wr),
    .ctl_rd  (ctl_rd),
    .data_wr (data_wr),
    .data_rd (data_rd),
    .pending (cmd_pending),
    .wdata   (wdata),
    .ev      (ev),
    .dwr_hit (dwr_hit)
  );

  cmd_state u_state (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .wdata    (wdata),
    .addr     (acc_addr),
    .code     (acc_code),
    .pending  (cmd_pending),
    .flush    (prefetch_flush),
    .reg_wr   (reg_wr),
    .reg_idx  (reg_idx),
    .reg_data (reg_data)
  );

  dma_trigger u_dma (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .dwr_hit   (dwr_hit),
    .xfer_bit  (wdata[7]),
    .dma_en    (dma_en),
    .src_mode  (src_mode),
    .dma_start (dma_start)
  );

  queue_flags #(.Q_DEPTH(Q_DEPTH), .LVL_W(LVL_W)) u_qf (
    .level (q_level),
    .empty (q_empty),
    .full  (q_full)
  );

  p_ctl_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && cmd_pending && (data_rd || data_wr || ctl_rd))
      |=> (!cmd_pending && prefetch_flush));
endmodule

// File: tb/ctl_cmd_latch_tb.sv
`timescale 1ns/1ps
module ctl_cmd_latch_tb;
  localparam int Q_DEPTH = 4;
  localparam int LVL_W   = $clog2(Q_DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_rd = 0, data_wr = 0, data_rd = 0;
  logic [15:0] wdata = '0;
  logic dma_en = 0;
  logic [1:0] src_mode = 2'b00;
  logic [LVL_W-1:0] q_level = '0;
  logic [15:0] acc_addr;
  logic [5:0] acc_code;
  logic cmd_pending, dma_start, prefetch_flush, reg_wr, q_empty, q_full;
  logic [4:0] reg_idx;
  logic [7:0] reg_data;

  always #2.5 clk = ~clk;

  ctl_cmd_latch #(.Q_DEPTH(Q_DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .data_wr(data_wr), .data_rd(data_rd), .wdata(wdata),
    .dma_en(dma_en), .src_mode(src_mode), .q_level(q_level),
    .acc_addr(acc_addr), .acc_code(acc_code), .cmd_pending(cmd_pending),
    .dma_start(dma_start), .prefetch_flush(prefetch_flush),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_data(reg_data),
    .q_empty(q_empty), .q_full(q_full)
  );

  typedef struct {
    logic [15:0] addr;
    logic [5:0]  code;
    logic        pend;
    logic        flush;
    logic        dma;
    logic        rw;
    logic [4:0]  idx;
    logic [7:0]  rdat;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_addr = '0;
  logic [5:0]  m_code = '0;
  logic        m_pend = 0, m_arm = 0;
  logic [4:0]  m_idx = '0;
  logic [7:0]  m_rdat = '0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic step(input logic cw, input logic cr, input logic dw, input logic dr,
                      input logic [15:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    ctl_wr = cw; ctl_rd = cr; data_wr = dw; data_rd = dr; wdata = v;
    e.flush = 0; e.dma = 0; e.rw = 0;
    if (cw) begin
      if (m_pend) begin
        m_addr[15:14] = v[1:0];
        m_code[5:2]   = v[7:4];
        m_pend = 0;
        e.flush = 1;
        if (v[7] && dma_en) begin
          if (src_mode == 2'b10) m_arm = 1;
          else begin e.dma = 1; m_arm = 0; end
        end else m_arm = 0;
      end else if (v[15:14] == 2'b10) begin
        e.rw = 1; m_idx = v[12:8]; m_rdat = v[7:0];
      end else begin
        m_addr[13:0] = v[13:0];
        m_code[1:0]  = v[15:14];
        m_pend = 1;
        m_arm = 0;
      end
    end else if (dw || dr) begin
      if (m_pend) begin m_pend = 0; e.flush = 1; end
      if (dw && m_arm) begin e.dma = 1; m_arm = 0; end
    end else if (cr) begin
      m_pend = 0;
    end
    e.addr = m_addr; e.code = m_code; e.pend = m_pend;
    e.idx = m_idx; e.rdat = m_rdat; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 16'h0000, tag);
  endtask

  // monitor: one expectation per clock, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      ctl_wr <= 0; ctl_rd <= 0; data_wr <= 0; data_rd <= 0;
    end
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({acc_addr, acc_code, cmd_pending} == {e.addr, e.code, e.pend}, e.tag,
            $sformatf("addr=%h code=%h pend=%b", acc_addr, acc_code, cmd_pending),
            $sformatf("addr=%h code=%h pend=%b", e.addr, e.code, e.pend));
      check({prefetch_flush, dma_start} == {e.flush, e.dma}, e.tag,
            $sformatf("flush=%b dma=%b", prefetch_flush, dma_start),
            $sformatf("flush=%b dma=%b", e.flush, e.dma));
      check(reg_wr == e.rw && (!e.rw || {reg_idx, reg_data} == {e.idx, e.rdat}), e.tag,
            $sformatf("rw=%b idx=%h dat=%h", reg_wr, reg_idx, reg_data),
            $sformatf("rw=%b idx=%h dat=%h", e.rw, e.idx, e.rdat));
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1: reset state
    check({acc_addr, acc_code, cmd_pending, dma_start, prefetch_flush, reg_wr} == '0, "R1",
          $sformatf("%h %h %b%b%b%b", acc_addr, acc_code, cmd_pending, dma_start, prefetch_flush, reg_wr),
          "0000 00 0000");

    // R2 / R3: plain two-word command
    step(1, 0, 0, 0, 16'h5234, "R2 head");
    step(1, 0, 0, 0, 16'h0002, "R3 tail");
    idle("R3 flush drops");
    // R2: upper address kept by a new head
    step(1, 0, 0, 0, 16'h0ABC, "R2 keep upper");
    step(1, 0, 0, 0, 16'h0073, "R3 tail2");

    // R4: register write
    step(1, 0, 0, 0, 16'h8F12, "R4 regwr");
    idle("R4 pulse drops");
    step(1, 0, 0, 0, 16'hB3C5, "R4 regwr2");

    // R5: data access cancels a half-written command
    step(1, 0, 0, 0, 16'h4111, "R5 head");
    step(0, 0, 0, 1, 16'h0000, "R5 data read cancel");
    step(1, 0, 0, 0, 16'h4222, "R5 head");
    step(0, 0, 1, 0, 16'h0000, "R5 data write cancel");
    step(0, 0, 1, 0, 16'h0000, "R5 no flush idle");

    // R6: status read cancels without flush
    step(1, 0, 0, 0, 16'hC333, "R6 head");
    step(0, 1, 0, 0, 16'h0000, "R6 status read");

    // R7: immediate DMA
    dma_en = 1; src_mode = 2'b00;
    step(1, 0, 0, 0, 16'h4000, "R7 head");
    step(1, 0, 0, 0, 16'h0080, "R7 start");
    idle("R7 pulse drops");
    src_mode = 2'b11;
    step(1, 0, 0, 0, 16'h4004, "R7 head copy");
    step(1, 0, 0, 0, 16'h0081, "R7 start copy");
    step(1, 0, 0, 0, 16'h4008, "R7 head bit5 clear");
    step(1, 0, 0, 0, 16'h0070, "R7 no start bit5");
    dma_en = 0;
    step(1, 0, 0, 0, 16'h4010, "R7 head disabled");
    step(1, 0, 0, 0, 16'h0080, "R7 no start disabled");

    // R8: fill waits for the next data write
    dma_en = 1; src_mode = 2'b10;
    step(1, 0, 0, 0, 16'h4020, "R8 head");
    step(1, 0, 0, 0, 16'h0080, "R8 no immediate");
    idle("R8 armed idle");
    step(0, 0, 1, 0, 16'h0000, "R8 fire");
    step(0, 0, 1, 0, 16'h0000, "R8 once");
    step(1, 0, 0, 0, 16'h4030, "R8 head");
    step(1, 0, 0, 0, 16'h0081, "R8 arm again");
    step(1, 0, 0, 0, 16'h4040, "R8 head disarms");
    step(1, 0, 0, 0, 16'h0010, "R8 tail no dma");
    step(0, 0, 1, 0, 16'h0000, "R8 stays silent");

    // R10: control write wins over coincident strobes
    dma_en = 0; src_mode = 2'b00;
    step(1, 0, 0, 0, 16'h4555, "R10 head");
    step(1, 1, 1, 1, 16'h0031, "R10 tail wins");
    step(1, 1, 0, 1, 16'h4666, "R10 head wins");
    idle("R10 pending held");

    // R9: queue status flags (combinational)
    @(negedge clk);
    q_level = 0; #0.5;
    check(q_empty === 1 && q_full === 0, "R9 level0", $sformatf("%b%b", q_empty, q_full), "10");
    q_level = 2; #0.5;
    check(q_empty === 0 && q_full === 0, "R9 level2", $sformatf("%b%b", q_empty, q_full), "00");
    q_level = LVL_W'(Q_DEPTH); #0.5;
    check(q_empty === 0 && q_full === 1, "R9 full", $sformatf("%b%b", q_empty, q_full), "01");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule